// File: doc/BRIEF.md
# Configuration Control Transaction Engine

This block runs one configuration access per command. A register bus gives it three 32-bit words: a data word at byte offset 0xA0, a control word at 0xA4 and a status word at 0xA8. Software first puts an operand in the data word. It then writes a control word with its start bit set. In the same clock edge the engine decodes the target, checks that it exists, and does the access. It also records completion and, if the access was refused, an error flag.

There are two kinds of target. The first is a table of oscillator frequencies that can be read and written. It has six main-board entries and a parameterised number of daughter-board entries, and every entry returns to a fixed value on reset. The second is a set of voltage readings that can only be read. A few accepted write-only functions stand for system actions. Two of them, power-off and restart, leave the block as one-cycle request pulses.

Top module: `cfgxact_engine`

## Requirements
- R1: After a synchronous reset the data, control and status words read 0, and both request outputs are low. The oscillator entries return to their defaults: main board 50000000, 23750000, 24000000, 24000000, 24000000, 24000000 for devices 0 to 5; daughter board entries from the DB_OSC_INIT parameter.
- R2: A write to the control word (0xA4) stores every bit except bit 31 (start) and bits 19:18, which always read back as 0. The fields are start [31], write [30], dcc [29:26], function [25:20], site [17:16], position [15:12] and device [11:0].
- R3: A write to the status word (0xA8) keeps only bits 1:0 of the written value. Bits 31:2 read as 0.
- R4: A control write with bit 31 set runs a transaction. Status bit 0 (done) becomes 1, and status bit 1 (error) becomes 1 exactly when the access is refused and 0 otherwise.
- R5: An access is refused when dcc is nonzero, when position is nonzero, or when site is 2 or 3. Site 0 is the main board and site 1 the daughter board. A refused access leaves the data word unchanged.
- R6: Reading function 1 (oscillator) on site 0 with device 0 to 5 loads that entry into the data word.
- R7: Writing function 1 stores the current data word into the addressed oscillator entry, and a later read returns it.
- R8: Function 1 on site 1 reaches DB_OSC_N entries. A device index at or beyond the end of either table is refused.
- R9: Function 2 (voltage) is read-only. Site 0, device 0 returns 3300000, and site 1 returns entry `device` of DB_VOLT_VAL when device < DB_VOLT_N. Any voltage write, or any other voltage device, is refused.
- R10: Writes of function 7, 8, 9 or 11 on site 0, device 0 are accepted. Function 8 raises shutdown_req and function 9 raises reboot_req, each for exactly the one cycle after the command edge. Reads of these functions, or other sites or devices, are refused and raise no request.
- R11: Any other function number is refused, and the data word is left unchanged.
- R12: A control write with bit 31 clear changes neither the status word nor the data word and runs no access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| shutdown_req | output | 1 | One-cycle power-off request |
| reboot_req | output | 1 | One-cycle restart request |

## Verification
A wrong decode shows up at the status word in the cycle right after the command edge, as a done/error pair that does not match the target. A corrupted oscillator entry stays hidden until a later read command moves it into the data word. Because of that, every write test is followed by a read-back, and the reset test reads the entries again after they have been overwritten. A refused access that still loads data is caught by planting a marker in the data word before each refusal. The request pulses are sampled in the cycle after the command and again one cycle later, to confirm their width.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;

    localparam logic [7:0]  REG_DATA = 8'hA0;
    localparam logic [7:0]  REG_CTRL = 8'hA4;
    localparam logic [7:0]  REG_STAT = 8'hA8;
    localparam int          MB_OSC_N = 6;
    localparam logic [31:0] MB_VIO_UV = 32'd3300000;

    typedef struct packed {
        logic        start;
        logic        wr;
        logic [3:0]  dcc;
        logic [5:0]  func;
        logic [1:0]  rsvd;
        logic [1:0]  site;
        logic [3:0]  pos;
        logic [11:0] dev;
    } cfg_cmd_t;

    typedef enum logic [5:0] {
        FN_OSC      = 6'd1,
        FN_VOLT     = 6'd2,
        FN_VIDMUX   = 6'd7,
        FN_OFF      = 6'd8,
        FN_RESTART  = 6'd9,
        FN_DISPMODE = 6'd11
    } cfg_fn_e;

    typedef struct packed {
        logic accept;     // target exists for this direction
        logic load_data;  // start & accept & read: result into data word
        logic osc_wr;     // start & accept & oscillator write
        logic off_req;
        logic restart_req;
    } cfg_res_t;

    function automatic logic [31:0] mb_osc_default(input int i);
        case (i)
            0:       return 32'd50000000;
            1:       return 32'd23750000;
            default: return 32'd24000000;
        endcase
    endfunction

endpackage

// File: rtl/cfgx_osc_bank.sv
module cfgx_osc_bank
    import cfgx_pkg::*;
#(
    parameter int N_MB = 6,
    parameter int N_DB = 3,
    parameter logic [N_DB*32-1:0] DB_INIT = '0,
    parameter int IW = $clog2(N_MB + N_DB)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [IW-1:0] idx,
    input  logic [31:0]   wdata,
    output logic [31:0]   rdata
);
    localparam int N = N_MB + N_DB;

    logic [31:0] ent [N];

    for (genvar g = 0; g < N; g++) begin : g_ent
        logic [31:0] q;
        if (g < N_MB) begin : g_mb
            localparam logic [31:0] RV = mb_osc_default(g);
            always_ff @(posedge clk) begin
                if (rst)                         q <= RV;
                else if (we && idx == IW'(g))    q <= wdata;
            end
        end else begin : g_db
            localparam logic [31:0] RV = DB_INIT[(g-N_MB)*32 +: 32];
            always_ff @(posedge clk) begin
                if (rst)                         q <= RV;
                else if (we && idx == IW'(g))    q <= wdata;
            end
        end
        assign ent[g] = q;
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < N; i++) begin
            if (idx == IW'(i)) rdata = ent[i];
        end
    end

endmodule

// File: rtl/cfgx_decode.sv
module cfgx_decode
    import cfgx_pkg::*;
#(
    parameter int DB_OSC_N  = 3,
    parameter int DB_VOLT_N = 2,
    parameter logic [DB_VOLT_N*32-1:0] DB_VOLT_VAL = '0,
    parameter int IW = $clog2(MB_OSC_N + DB_OSC_N)
) (
    input  cfg_cmd_t      cmd,
    input  logic [31:0]   osc_rd,
    output cfg_res_t      res,
    output logic [IW-1:0] osc_idx,
    output logic [31:0]   rd_val
);
    logic        base_ok, mb0, dev_in, acc, ld, ow, off, rs;
    logic [31:0] volt_db;
    logic        volt_hit;

    assign base_ok = (cmd.dcc == '0) && (cmd.pos == '0) && !cmd.site[1];
    assign mb0     = (cmd.site == 2'd0) && (cmd.dev == '0);
    assign dev_in  = cmd.site[0] ? (32'(cmd.dev) < 32'(DB_OSC_N))
                                 : (32'(cmd.dev) < 32'(MB_OSC_N));
    assign osc_idx = IW'(32'(cmd.dev) + (cmd.site[0] ? 32'(MB_OSC_N) : 32'd0));

    always_comb begin
        volt_db  = '0;
        volt_hit = 1'b0;
        for (int i = 0; i < DB_VOLT_N; i++) begin
            if (32'(cmd.dev) == 32'(i)) begin
                volt_db  = DB_VOLT_VAL[i*32 +: 32];
                volt_hit = 1'b1;
            end
        end
    end

    always_comb begin
        acc    = 1'b0;
        ld     = 1'b0;
        ow     = 1'b0;
        off    = 1'b0;
        rs     = 1'b0;
        rd_val = '0;
        if (base_ok) begin
            case (cmd.func)
                FN_OSC: begin
                    if (dev_in) begin
                        acc = 1'b1;
                        if (cmd.wr) ow = 1'b1;
                        else begin
                            ld     = 1'b1;
                            rd_val = osc_rd;
                        end
                    end
                end
                FN_VOLT: begin
                    if (!cmd.wr && mb0) begin
                        acc = 1'b1; ld = 1'b1; rd_val = MB_VIO_UV;
                    end else if (!cmd.wr && cmd.site[0] && volt_hit) begin
                        acc = 1'b1; ld = 1'b1; rd_val = volt_db;
                    end
                end
                FN_VIDMUX, FN_DISPMODE: acc = cmd.wr && mb0;
                FN_OFF: begin
                    acc = cmd.wr && mb0;
                    off = cmd.wr && mb0;
                end
                FN_RESTART: begin
                    acc = cmd.wr && mb0;
                    rs  = cmd.wr && mb0;
                end
                default: ;
            endcase
        end
    end

    assign res.accept      = acc;
    assign res.load_data   = cmd.start && ld;
    assign res.osc_wr      = cmd.start && ow;
    assign res.off_req     = cmd.start && off;
    assign res.restart_req = cmd.start && rs;

endmodule

// File: rtl/cfgxact_engine.sv
module cfgxact_engine
    import cfgx_pkg::*;
#(
    parameter int DB_OSC_N  = 3,
    parameter logic [DB_OSC_N*32-1:0] DB_OSC_INIT =
        {32'd33000000, 32'd66000000, 32'd45000000},
    parameter int DB_VOLT_N = 2,
    parameter logic [DB_VOLT_N*32-1:0] DB_VOLT_VAL =
        {32'd1000000, 32'd900000}
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_wr,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        shutdown_req,
    output logic        reboot_req
);
    localparam int IW = $clog2(MB_OSC_N + DB_OSC_N);

    cfg_cmd_t      cmd, ctrl_next, ctrl_q;
    cfg_res_t      res;
    logic [31:0]   data_q, osc_rd, rd_val;
    logic [1:0]    stat_q;
    logic [IW-1:0] osc_idx;
    logic          ctrl_wr;

    assign cmd     = cfg_cmd_t'(bus_wdata);
    assign ctrl_wr = bus_wr && (bus_addr == REG_CTRL);

    always_comb begin
        ctrl_next       = cmd;
        ctrl_next.start = 1'b0;
        ctrl_next.rsvd  = 2'b00;
    end

    cfgx_decode #(
        .DB_OSC_N   (DB_OSC_N),
        .DB_VOLT_N  (DB_VOLT_N),
        .DB_VOLT_VAL(DB_VOLT_VAL),
        .IW         (IW)
    ) u_dec (
        .cmd    (cmd),
        .osc_rd (osc_rd),
        .res    (res),
        .osc_idx(osc_idx),
        .rd_val (rd_val)
    );

    cfgx_osc_bank #(
        .N_MB   (MB_OSC_N),
        .N_DB   (DB_OSC_N),
        .DB_INIT(DB_OSC_INIT),
        .IW     (IW)
    ) u_osc (
        .clk  (clk),
        .rst  (rst),
        .we   (ctrl_wr && res.osc_wr),
        .idx  (osc_idx),
        .wdata(data_q),
        .rdata(osc_rd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q       <= '0;
            ctrl_q       <= '0;
            stat_q       <= '0;
            shutdown_req <= 1'b0;
            reboot_req   <= 1'b0;
        end else begin
            shutdown_req <= 1'b0;
            reboot_req   <= 1'b0;
            if (bus_wr) begin
                case (bus_addr)
                    REG_DATA: data_q <= bus_wdata;
                    REG_CTRL: begin
                        ctrl_q <= ctrl_next;
                        if (cmd.start) begin
                            stat_q       <= {~res.accept, 1'b1};
                            shutdown_req <= res.off_req;
                            reboot_req   <= res.restart_req;
                            if (res.load_data) data_q <= rd_val;
                        end
                    end
                    REG_STAT: stat_q <= bus_wdata[1:0];
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        case (bus_addr)
            REG_DATA: bus_rdata = data_q;
            REG_CTRL: bus_rdata = ctrl_q;
            REG_STAT: bus_rdata = {30'd0, stat_q};
            default:  bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/cfgx_checker.sv
module cfgx_checker (
    input logic        clk,
    input logic        rst,
    input logic        bus_wr,
    input logic [7:0]  bus_addr,
    input logic [31:0] bus_wdata,
    input logic [31:0] data_q,
    input logic [31:0] ctrl_q,
    input logic [1:0]  stat_q,
    input logic        shutdown_req,
    input logic        reboot_req
);
    logic ctl_w, go;
    assign ctl_w = bus_wr && (bus_addr == 8'hA4);
    assign go    = ctl_w && bus_wdata[31];

    p_ctrl_mask_r2: assert property (@(posedge clk) disable iff (rst)
        ctl_w |=> ctrl_q == ($past(bus_wdata) & 32'h7FF3_FFFF));

    p_stat_store_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 8'hA8) |=> stat_q == $past(bus_wdata[1:0]));

    p_start_done_r4: assert property (@(posedge clk) disable iff (rst)
        go |=> stat_q[0]);

    p_reject_r5: assert property (@(posedge clk) disable iff (rst)
        (go && (bus_wdata[29:26] != 4'd0 || bus_wdata[15:12] != 4'd0 || bus_wdata[17]))
        |=> (stat_q == 2'b11) && $stable(data_q));

    p_off_src_r10: assert property (@(posedge clk) disable iff (rst)
        shutdown_req |-> $past(go && bus_wdata[30] && bus_wdata[25:20] == 6'd8));

    p_restart_src_r10: assert property (@(posedge clk) disable iff (rst)
        reboot_req |-> $past(go && bus_wdata[30] && bus_wdata[25:20] == 6'd9));

    p_nostart_r12: assert property (@(posedge clk) disable iff (rst)
        (ctl_w && !bus_wdata[31]) |=> $stable(stat_q) && $stable(data_q));

endmodule

bind cfgxact_engine cfgx_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .data_q      (data_q),
    .ctrl_q      (ctrl_q),
    .stat_q      (stat_q),
    .shutdown_req(shutdown_req),
    .reboot_req  (reboot_req)
);

// File: tb/sim_cfgxact_engine.sv
module sim_cfgxact_engine;
    localparam logic [7:0] A_DATA = 8'hA0;
    localparam logic [7:0] A_CTRL = 8'hA4;
    localparam logic [7:0] A_STAT = 8'hA8;
    localparam logic [31:0] MARK  = 32'hDEAD_BEEF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        shutdown_req, reboot_req;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  finished = 0;

    always #10 clk = ~clk;

    cfgxact_engine u0 (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .shutdown_req(shutdown_req), .reboot_req(reboot_req)
    );

    function automatic logic [31:0] mk(input bit st, input bit w, input int dcc,
                                       input int fn, input int site, input int pos,
                                       input int dev);
        return {st, w, dcc[3:0], fn[5:0], 2'b00, site[1:0], pos[3:0], dev[11:0]};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    // run a transaction and check status and data word
    task automatic xact(input string req, input bit w, input int dcc, input int fn,
                        input int site, input int pos, input int dev,
                        input logic [1:0] exp_st, input logic [31:0] exp_data);
        logic [31:0] v;
        wr(A_CTRL, mk(1, w, dcc, fn, site, pos, dev));
        rd(A_STAT, v); chk({req, " status"}, v, {30'd0, exp_st});
        rd(A_DATA, v); chk({req, " data"}, v, exp_data);
    endtask

    task automatic t_reset_state();
        logic [31:0] v;
        rd(A_DATA, v); chk("R1 data", v, 0);
        rd(A_CTRL, v); chk("R1 ctrl", v, 0);
        rd(A_STAT, v); chk("R1 status", v, 0);
        chk("R1 pulses", {30'd0, shutdown_req, reboot_req}, 0);
    endtask

    task automatic t_ctrl_fields();
        logic [31:0] v;
        wr(A_CTRL, 32'h4ABC_D123);            // start clear, bits 19:18 set
        rd(A_CTRL, v); chk("R2 ctrl mask", v, 32'h4AB0_D123);
        rd(A_STAT, v); chk("R12 status held", v, 0);
        rd(A_DATA, v); chk("R12 data held", v, 0);
        wr(A_CTRL, mk(1, 0, 0, 1, 0, 0, 3));
        rd(A_CTRL, v); chk("R2 start not stored", v, mk(0, 0, 0, 1, 0, 0, 3));
    endtask

    task automatic t_status_write();
        logic [31:0] v;
        wr(A_STAT, 32'hFFFF_FFFE);
        rd(A_STAT, v); chk("R3 status keep 1:0", v, 32'd2);
        wr(A_STAT, 32'h0000_0005);
        rd(A_STAT, v); chk("R3 status keep 1:0", v, 32'd1);
        wr(A_STAT, 0);
        rd(A_STAT, v); chk("R3 status clear", v, 0);
    endtask

    task automatic t_mb_osc_read();
        logic [31:0] exp [6] = '{32'd50000000, 32'd23750000, 32'd24000000,
                                 32'd24000000, 32'd24000000, 32'd24000000};
        for (int i = 0; i < 6; i++) xact("R6 R4 mb osc read", 0, 0, 1, 0, 0, i, 2'b01, exp[i]);
        wr(A_DATA, MARK);
        xact("R8 mb osc dev 6", 0, 0, 1, 0, 0, 6, 2'b11, MARK);
    endtask

    task automatic t_osc_write();
        wr(A_DATA, 32'd12345678);
        xact("R7 osc write", 1, 0, 1, 0, 0, 2, 2'b01, 32'd12345678);
        wr(A_DATA, 0);
        xact("R7 osc readback", 0, 0, 1, 0, 0, 2, 2'b01, 32'd12345678);
        xact("R7 neighbour intact", 0, 0, 1, 0, 0, 3, 2'b01, 32'd24000000);
    endtask

    task automatic t_db_osc();
        logic [31:0] exp [3] = '{32'd45000000, 32'd66000000, 32'd33000000};
        for (int i = 0; i < 3; i++) xact("R8 db osc read", 0, 0, 1, 1, 0, i, 2'b01, exp[i]);
        wr(A_DATA, MARK);
        xact("R8 db osc past end", 0, 0, 1, 1, 0, 3, 2'b11, MARK);
        wr(A_DATA, 32'd77000000);
        xact("R8 db osc write", 1, 0, 1, 1, 0, 1, 2'b01, 32'd77000000);
        wr(A_DATA, 0);
        xact("R8 db osc readback", 0, 0, 1, 1, 0, 1, 2'b01, 32'd77000000);
        xact("R8 mb dev1 untouched", 0, 0, 1, 0, 0, 1, 2'b01, 32'd23750000);
    endtask

    task automatic t_voltage();
        xact("R9 mb volt", 0, 0, 2, 0, 0, 0, 2'b01, 32'd3300000);
        xact("R9 db volt 0", 0, 0, 2, 1, 0, 0, 2'b01, 32'd900000);
        xact("R9 db volt 1", 0, 0, 2, 1, 0, 1, 2'b01, 32'd1000000);
        wr(A_DATA, MARK);
        xact("R9 mb volt dev1", 0, 0, 2, 0, 0, 1, 2'b11, MARK);
        xact("R9 db volt past end", 0, 0, 2, 1, 0, 2, 2'b11, MARK);
        xact("R9 volt write", 1, 0, 2, 0, 0, 0, 2'b11, MARK);
    endtask

    task automatic t_reject();
        wr(A_DATA, MARK);
        xact("R5 dcc nonzero", 0, 1, 1, 0, 0, 0, 2'b11, MARK);
        xact("R5 position nonzero", 0, 0, 1, 0, 4, 0, 2'b11, MARK);
        xact("R5 site 2", 0, 0, 1, 2, 0, 0, 2'b11, MARK);
        xact("R5 site 3", 0, 0, 2, 3, 0, 0, 2'b11, MARK);
        xact("R4 error clears on success", 0, 0, 1, 0, 0, 0, 2'b01, 32'd50000000);
    endtask

    task automatic t_side_effects();
        logic [31:0] v;
        wr(A_CTRL, mk(1, 1, 0, 7, 0, 0, 0));
        rd(A_STAT, v); chk("R10 fn7 accepted", v, 1);
        chk("R10 fn7 no pulse", {30'd0, shutdown_req, reboot_req}, 0);
        wr(A_CTRL, mk(1, 1, 0, 11, 0, 0, 0));
        rd(A_STAT, v); chk("R10 fn11 accepted", v, 1);
        wr(A_CTRL, mk(1, 1, 0, 8, 0, 0, 0));
        chk("R10 shutdown pulse", {30'd0, shutdown_req, reboot_req}, 32'd2);
        rd(A_STAT, v); chk("R10 fn8 accepted", v, 1);
        @(negedge clk);
        chk("R10 shutdown width", {30'd0, shutdown_req, reboot_req}, 0);
        wr(A_CTRL, mk(1, 1, 0, 9, 0, 0, 0));
        chk("R10 reboot pulse", {30'd0, shutdown_req, reboot_req}, 32'd1);
        @(negedge clk);
        chk("R10 reboot width", {30'd0, shutdown_req, reboot_req}, 0);
        wr(A_CTRL, mk(1, 0, 0, 8, 0, 0, 0));
        chk("R10 fn8 read no pulse", {30'd0, shutdown_req, reboot_req}, 0);
        rd(A_STAT, v); chk("R10 fn8 read refused", v, 3);
        wr(A_CTRL, mk(1, 1, 0, 9, 0, 0, 1));
        chk("R10 fn9 dev1 no pulse", {30'd0, shutdown_req, reboot_req}, 0);
        rd(A_STAT, v); chk("R10 fn9 dev1 refused", v, 3);
    endtask

    task automatic t_unknown();
        wr(A_DATA, MARK);
        xact("R11 fn3 read", 0, 0, 3, 0, 0, 0, 2'b11, MARK);
        xact("R11 fn63 write", 1, 0, 63, 0, 0, 0, 2'b11, MARK);
        xact("R11 fn0 read", 0, 0, 0, 1, 0, 0, 2'b11, MARK);
    endtask

    task automatic t_reset_restore();
        do_reset();
        t_reset_state();
        xact("R1 mb osc restored", 0, 0, 1, 0, 0, 2, 2'b01, 32'd24000000);
        xact("R1 db osc restored", 0, 0, 1, 1, 0, 1, 2'b01, 32'd66000000);
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=0x%08h expected=0x%08h", 0, 1);
            report();
        end
    end

    initial begin
        do_reset();
        t_reset_state();
        t_ctrl_fields();
        t_status_write();
        t_mb_osc_read();
        t_osc_write();
        t_db_osc();
        t_voltage();
        t_reject();
        t_side_effects();
        t_unknown();
        t_reset_restore();
        finished = 1;
        report();
    end

endmodule